// File: doc/BRIEF.md
# Serial SAR ADC Frame Controller

This block is the digital front end of a 10-bit successive-approximation converter that talks to a DSP through four wires: an active-low chip select, a frame sync, a serial clock and a data output that can float. Chip select, frame sync and serial clock arrive as levels that are already synchronous to the block clock. The block compares each level with its value one clock earlier to find the edges. The conversion result comes from the analog side as a 10-bit parallel word. The block captures that word when the sampling phase ends, then sends it out one bit at a time.

When chip select falls, the block reads the frame-sync level to choose DSP mode or microcontroller mode. In DSP mode it waits in auto power-down. A frame-sync rising edge wakes it and starts a 16-bit frame: six zero bits, during which the input is being sampled, and then the ten result bits, most significant first. After the last bit the output floats, and power-down follows on the next serial-clock falling edge. The floating output appears at the ports as `dout_oe` low, with `dout` held at 0. Microcontroller-mode timing is not modelled: in that mode the block stays quiet.

States: OFF (chip select high), MCU (microcontroller mode, parked), SLEEP (auto power-down), WAKE (frame sync seen, first zero driven), SAMPLE (sampling after frame sync went low), CONV (result bits shifting), HIZ (output floating, waiting for the closing falling edge). Transitions: OFF to MCU or SLEEP on a chip-select fall; SLEEP to WAKE on a frame-sync rise; WAKE to SAMPLE on a serial-clock fall with frame sync low; WAKE or SAMPLE to CONV on the rising edge that drives the sixth bit; CONV to HIZ on the rising edge after bit 16; HIZ to SLEEP on the next serial-clock fall; any state to OFF while chip select is high.

Top module: `sar_frame_ctrl`

## Requirements
- R1: During and right after an asynchronous reset, `dout_oe`, `pwr_down`, `dsp_mode` and `dout` are all 0.
- R2: At a chip-select falling edge `dsp_mode` takes the inverse of the frame-sync level (frame sync low gives 1, high gives 0). It holds that value until the next chip-select fall.
- R3: In DSP mode, after chip select falls the block sits in power-down: `pwr_down`=1 and `dout_oe`=0 until a frame-sync rise.
- R4: A frame-sync rise during power-down clears `pwr_down` and sets `dout_oe` one clock later, with `dout`=0 as frame bit 1.
- R5: The frame is 16 bits, six zeros followed by the result MSB first. Bit 1 appears at the frame-sync rise, and each later serial-clock rising edge drives the next bit, so rise k (k=2..16) drives bit k.
- R6: The result is captured on the rising edge that drives bit 6. Later changes of the result input do not alter the frame.
- R7: The rising edge after bit 16 (the 17th counting the frame-sync rise) clears `dout_oe`.
- R8: The serial-clock falling edge after the output floats sets `pwr_down` again. A further frame-sync rise starts a new identical-format frame.
- R9: While chip select is high, `dout_oe` and `pwr_down` are 0 one clock later, from any state including mid-frame.
- R10: In microcontroller mode, frame-sync and serial-clock activity never enables the output or power-down flag.
- R11: A frame-sync rise or fall while result bits are shifting is ignored and the frame completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| fs | input | 1 | Frame sync |
| sclk | input | 1 | Serial clock level, sampled by clk |
| adc_result | input | 10 | Parallel conversion result |
| dout | output | 1 | Serial data, 0 while not enabled |
| dout_oe | output | 1 | Output enable; low means high impedance |
| pwr_down | output | 1 | Auto power-down status |
| dsp_mode | output | 1 | 1 when DSP mode was selected |

## Verification
The bench drives whole frames with result words chosen to expose bit-order and off-by-one faults. A design that captured the result a rising edge early or late, or lagged the bits wrongly, would shift the word or pick up the value changed after capture. It checks that the output floats exactly at the 17th rise and that power-down returns only on the following fall, so a counter compared against the wrong limit shows up as a truncated or stretched enable window. Directed cases raise chip select in mid-frame, select microcontroller mode and toggle frame sync in mid-frame. A design that ignored the chip-select level, latched the mode at the wrong time or restarted on a stray frame sync would enable the output where it must stay floating or corrupt the frame.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_MCU,
        ST_SLEEP,
        ST_WAKE,
        ST_SAMPLE,
        ST_CONV,
        ST_HIZ
    } sfc_state_e;
endpackage

// File: rtl/sfc_level_reg.sv
// Holds the previous clock's level of each interface input for edge finding.
module sfc_level_reg #(
    parameter int          N       = 3,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_in,
    output logic [N-1:0] lvl_prev
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_prev[g] <= RST_VAL[g];
            else        lvl_prev[g] <= lvl_in[g];
        end
    end
endmodule

// File: rtl/sfc_shifter.sv
// Bit counter and output shifter for one frame.
module sfc_shifter #(
    parameter int RES_W   = 10,
    parameter int FRAME_W = 16,
    parameter int CNT_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             step,
    input  logic [RES_W-1:0] result,
    output logic [CNT_W-1:0] cnt,
    output logic             bit_out
);
    localparam int PAD = FRAME_W - RES_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic [RES_W-1:0] sh_q;
    logic             bit_q;

    assign cnt_nxt = cnt_q + CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sh_q  <= '0;
            bit_q <= 1'b0;
        end else if (start) begin
            cnt_q <= CNT_W'(1);
            bit_q <= 1'b0;
        end else if (step) begin
            cnt_q <= cnt_nxt;
            if (cnt_nxt <= CNT_W'(PAD)) begin
                bit_q <= 1'b0;
                if (cnt_nxt == CNT_W'(PAD)) sh_q <= result;
            end else begin
                bit_q <= sh_q[RES_W-1];
                sh_q  <= {sh_q[RES_W-2:0], 1'b0};
            end
        end
    end

    assign cnt     = cnt_q;
    assign bit_out = bit_q;
endmodule

// File: rtl/sar_frame_ctrl.sv
module sar_frame_ctrl #(
    parameter int RES_W   = 10,
    parameter int FRAME_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             fs,
    input  logic             sclk,
    input  logic [RES_W-1:0] adc_result,
    output logic             dout,
    output logic             dout_oe,
    output logic             pwr_down,
    output logic             dsp_mode
);
    import sfc_pkg::*;

    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam int PAD   = FRAME_W - RES_W;
    localparam int NSIG  = 3;
    // bit 0 chip select (idles high), bit 1 frame sync, bit 2 serial clock
    localparam logic [NSIG-1:0] LVL_RST = 3'b001;

    sfc_state_e       st_q, st_d;
    logic             mode_q;
    logic [NSIG-1:0]  lvl_now, lvl_prev;
    logic             cs_fall, fs_rise, sclk_rise, sclk_fall;
    logic             frm_start, frm_step, at_pad, at_end;
    logic [CNT_W-1:0] cnt;
    logic             bit_raw;

    assign lvl_now = {sclk, fs, cs_n};

    sfc_level_reg #(.N(NSIG), .RST_VAL(LVL_RST)) lvl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_in  (lvl_now),
        .lvl_prev(lvl_prev)
    );

    assign cs_fall   = !cs_n &&  lvl_prev[0];
    assign fs_rise   =  fs   && !lvl_prev[1];
    assign sclk_rise =  sclk && !lvl_prev[2];
    assign sclk_fall = !sclk &&  lvl_prev[2];

    assign at_pad    = (cnt == CNT_W'(PAD - 1));
    assign at_end    = (cnt == CNT_W'(FRAME_W));
    assign frm_start = !cs_n && (st_q == ST_SLEEP) && fs_rise;
    assign frm_step  = !cs_n && sclk_rise &&
                       (st_q inside {ST_WAKE, ST_SAMPLE, ST_CONV});

    sfc_shifter #(.RES_W(RES_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) shf_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (frm_start),
        .step   (frm_step),
        .result (adc_result),
        .cnt    (cnt),
        .bit_out(bit_raw)
    );

    // next-state decision
    always_comb begin
        st_d = st_q;
        if (cs_n) begin
            st_d = ST_OFF;
        end else begin
            unique case (st_q)
                ST_OFF:    if (cs_fall) st_d = fs ? ST_MCU : ST_SLEEP;
                ST_MCU:    st_d = ST_MCU;
                ST_SLEEP:  if (fs_rise) st_d = ST_WAKE;
                ST_WAKE: begin
                    if (sclk_rise && at_pad)       st_d = ST_CONV;
                    else if (sclk_fall && !fs)     st_d = ST_SAMPLE;
                end
                ST_SAMPLE: if (sclk_rise && at_pad) st_d = ST_CONV;
                ST_CONV:   if (sclk_rise && at_end) st_d = ST_HIZ;
                ST_HIZ:    if (sclk_fall) st_d = ST_SLEEP;
                default:   st_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_OFF;
            mode_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (cs_fall) mode_q <= !fs;
        end
    end

    // outputs
    always_comb begin
        dout_oe  = st_q inside {ST_WAKE, ST_SAMPLE, ST_CONV};
        pwr_down = (st_q == ST_SLEEP);
        dout     = bit_raw && dout_oe;
        dsp_mode = mode_q;
    end

    // R9
    cs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!dout_oe && !pwr_down));

    // R3
    pd_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwr_down && dout_oe));

    // R4
    oe_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe) |-> ($past(pwr_down) && $past(fs_rise)));

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dsp_mode) |-> $past(cs_fall));

    // R5
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && (cnt <= CNT_W'(PAD))) |-> !dout);

    // R7
    oe_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dout_oe) |-> ($past(cs_n) || ($past(cnt) == CNT_W'(FRAME_W))));
endmodule

// File: tb/sar_frame_ctrl_tb.sv
module sar_frame_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       fs = 1'b0;
    logic       sclk = 1'b0;
    logic [9:0] adc_result = '0;
    logic       dout, dout_oe, pwr_down, dsp_mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam int NV = 6;
    localparam logic [9:0]  STIM [NV] = '{10'h000, 10'h3FF, 10'h2AA, 10'h155, 10'h201, 10'h0F0};
    localparam logic [15:0] EXPW [NV] = '{16'h0000, 16'h03FF, 16'h02AA, 16'h0155, 16'h0201, 16'h00F0};
    localparam bit          GLT  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

    always #5 clk = ~clk;

    sar_frame_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .fs(fs), .sclk(sclk),
        .adc_result(adc_result), .dout(dout), .dout_oe(dout_oe),
        .pwr_down(pwr_down), .dsp_mode(dsp_mode)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_frame(input logic [9:0] res, input bit glitch, input logic [15:0] expw);
        logic [15:0] word;
        bit oe_ok;
        adc_result = res;
        sclk = 1'b1; settle();
        fs = 1'b1;   settle();
        // R4: wake from power-down, first bit zero
        chk(dout_oe && !pwr_down && !dout, "R4 wake", {13'b0, dout_oe, pwr_down, dout}, 16'h4);
        word = '0;
        word[15] = dout;
        oe_ok = dout_oe;
        for (int k = 2; k <= 16; k++) begin
            sclk = 1'b0; settle();
            sclk = 1'b1; settle();
            word[16-k] = dout;
            oe_ok = oe_ok && dout_oe;
            if (k == 2) fs = 1'b0;
            if (k == 8) adc_result = ~res;        // R6 late change
            if (glitch && k == 10) fs = 1'b1;     // R11 stray frame sync
            if (glitch && k == 12) fs = 1'b0;
        end
        // R5 / R6 / R11: frame content
        chk(word == expw, glitch ? "R11 frame" : "R5 R6 frame", word, expw);
        chk(oe_ok, "R5 enable held", {15'b0, oe_ok}, 16'h1);
        sclk = 1'b0; settle();
        sclk = 1'b1; settle();
        // R7: float after bit 16
        chk(!dout_oe && !pwr_down, "R7 float", {14'b0, dout_oe, pwr_down}, 16'h0);
        sclk = 1'b0; settle();
        // R8: power-down on following fall
        chk(pwr_down && !dout_oe, "R8 powerdown", {14'b0, dout_oe, pwr_down}, 16'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(!dout_oe && !pwr_down && !dsp_mode && !dout, "R1 in reset",
            {12'b0, dout_oe, pwr_down, dsp_mode, dout}, 16'h0);
        rst_n = 1'b1;
        settle();
        chk(!dout_oe && !pwr_down && !dsp_mode && !dout, "R1 after reset",
            {12'b0, dout_oe, pwr_down, dsp_mode, dout}, 16'h0);

        // R2 / R3: select DSP mode
        cs_n = 1'b0; settle();
        chk(dsp_mode, "R2 dsp select", {15'b0, dsp_mode}, 16'h1);
        chk(pwr_down && !dout_oe, "R3 idle powerdown", {14'b0, dout_oe, pwr_down}, 16'h1);

        for (int i = 0; i < NV; i++) run_frame(STIM[i], GLT[i], EXPW[i]);

        // R9: chip select raised mid-frame
        adc_result = 10'h123;
        sclk = 1'b1; settle();
        fs = 1'b1;   settle();
        sclk = 1'b0; settle();
        sclk = 1'b1; settle();
        chk(dout_oe, "R9 frame running", {15'b0, dout_oe}, 16'h1);
        cs_n = 1'b1; settle();
        chk(!dout_oe && !pwr_down, "R9 cs high", {14'b0, dout_oe, pwr_down}, 16'h0);
        sclk = 1'b0; settle();
        sclk = 1'b1; settle();
        chk(!dout_oe && !pwr_down, "R9 stays off", {14'b0, dout_oe, pwr_down}, 16'h0);

        // R2 / R10: microcontroller mode
        cs_n = 1'b0; settle();
        chk(!dsp_mode, "R2 mcu select", {15'b0, dsp_mode}, 16'h0);
        fs = 1'b0; settle();
        fs = 1'b1; settle();
        for (int k = 0; k < 4; k++) begin
            sclk = 1'b0; settle();
            sclk = 1'b1; settle();
        end
        chk(!dout_oe && !pwr_down, "R10 mcu quiet", {14'b0, dout_oe, pwr_down}, 16'h0);
        chk(!dsp_mode, "R2 mode held", {15'b0, dsp_mode}, 16'h0);

        // back to DSP mode, one more frame after re-select
        cs_n = 1'b1; fs = 1'b0; settle();
        cs_n = 1'b0; settle();
        chk(dsp_mode && pwr_down, "R2 R3 reselect", {14'b0, dsp_mode, pwr_down}, 16'h3);
        run_frame(10'h3C5, 1'b0, 16'h03C5);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule